// File: doc/BRIEF.md
# Synchronous Serial Shifter with Programmable Clock

This block is the clocked, byte-wide mode of a serial channel. Each transfer sends one byte and receives one byte at the same time. Both bytes move least-significant bit first, and every bit is tied to a serial clock. The host writes the transmit byte, selects the clock source and divider, and pulses `start`. It then watches `busy` and `done` and reads the received byte from `rxData`.

As clock master, the block derives the serial clock from the system clock. The serial clock idles high, and its period can be set from 16 to 8192 system cycles. As slave, the block takes the serial clock from an input pin. The pin is resynchronised through two flops, and rising edges are detected in the system clock domain.

In both modes, input data is captured on the serial clock's rising edge. The next output bit appears a short, fixed number of system cycles after that edge, so the outgoing data never changes at the sampling instant.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, `busy`=0, `done`=0, `rxData`=0, `txd`=1, `sclkOut`=1 and `sclkOe`=0.
- R2: In master mode (`masterMode`=1 at start), `sclkOe` is 1 and `sclkOut` idles high. With effective half period H = max(`divSel`,7)+1 system cycles, the first falling edge comes H cycles after the start is accepted, and each full period that follows lasts 2H cycles.
- R3: Bit 0 of the transmit byte is on `txd` from the cycle after the start is accepted. Each later bit appears exactly 2 system cycles after the serial clock rising edge that sampled the previous bit.
- R4: `rxd` is sampled on each serial clock rising edge. The first sampled bit lands in `rxData` bit 0 and the eighth lands in bit 7.
- R5: `busy` rises the cycle after an accepted start, and `done` clears at that same edge. One cycle after the eighth rising edge, `busy` falls, `done` rises and `rxData` takes the received byte.
- R6: A `divSel` value below 7 acts as 7, which gives a minimum serial clock period of 16 system cycles.
- R7: In slave mode (`masterMode`=0 at start), `sclkOe` is 0 and `sclkOut` stays high. Rising edges of `sclkIn` pass through a two-flop synchroniser. `done` is set 4 system cycles after the eighth rising edge at the pin (clock period of at least 16 cycles).
- R8: A `start` pulse while `busy` is 1 is ignored. The transfer in progress, its transmit bits and its timing are unchanged.
- R9: `masterMode` and `divSel` are captured when a start is accepted. Changes to them during a transfer have no effect on that transfer.
- R10: After a transfer ends, `txd` keeps the last transmitted bit until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| masterMode | input | 1 | 1 = generate serial clock, 0 = follow `sclkIn`; captured at start |
| divSel | input | 12 | Half-period select, H = max(divSel,7)+1 cycles; captured at start |
| txData | input | 8 | Byte to send, loaded at start |
| start | input | 1 | Begin a transfer; ignored while busy |
| rxd | input | 1 | Serial data in |
| sclkIn | input | 1 | External serial clock (slave mode) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer finished; clears at next start |
| rxData | output | 8 | Received byte |
| txd | output | 1 | Serial data out |
| sclkOut | output | 1 | Generated serial clock, idle high |
| sclkOe | output | 1 | Drive enable for `sclkOut` (1 in master mode) |

## Verification
Most internal faults show up at the pins within one serial clock period. A wrong half-period counter or a failed divider clamp stretches or shrinks the first falling edge, which the bench measures in exact system cycles. A broken bit counter makes `busy` fall one period early or late. A misrouted shift register puts a wrong bit on `txd` at the very next rising edge. A wrong hold delay is caught one or two cycles after that edge. A synchroniser with the wrong depth moves the slave-mode `done` by a cycle. A failure to capture `divSel` or `masterMode` at start shows up as a changed period in the middle of a transfer.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  // strobes passed from control to the shift datapath
  typedef struct packed {
    logic loadTx;     // load transmit byte, present bit 0
    logic sampleRx;   // serial clock rising edge: shift rxd in
    logic driveNext;  // hold time elapsed: present next bit
    logic captureRx;  // transfer complete: publish received byte
  } shiftCtl_t;
endpackage

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HOLD_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftCtl_t         ctl,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxd,
  output logic              txd,
  output logic [DATA_W-1:0] rxData
);
  logic [DATA_W-1:0] shiftR;
  logic [DATA_W-1:0] rxR;
  logic              txdR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftR <= '0;
      rxR    <= '0;
      txdR   <= 1'b1;
    end else begin
      if (ctl.loadTx) begin
        shiftR <= txData;
        txdR   <= txData[0];
      end else if (ctl.sampleRx) begin
        shiftR <= {rxd, shiftR[DATA_W-1:1]};
      end
      if (ctl.driveNext) txdR <= shiftR[0];
      if (ctl.captureRx) rxR <= shiftR;
    end
  end

  assign txd    = txdR;
  assign rxData = rxR;

  // R3
  txd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (HOLD_CYC > 1 && ctl.sampleRx) |=> $stable(txdR));
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_W    = 12,
  parameter int MIN_HALF = 7,
  parameter int HOLD_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             masterMode,
  input  logic [DIV_W-1:0] divSel,
  input  logic             sclkIn,
  output shiftCtl_t        ctl,
  output logic             busy,
  output logic             done,
  output logic             sclkOut,
  output logic             sclkOe
);
  localparam int BIT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam logic [DIV_W-1:0]  MIN_LIM   = DIV_W'(MIN_HALF);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(DATA_W - 1);
  localparam logic [HOLD_W-1:0] HOLD_INIT = HOLD_W'(HOLD_CYC - 1);

  logic              busyR, doneR, modeR, sclkR, finPend, holdPend;
  logic [DIV_W-1:0]  limR, halfCnt, limIn;
  logic [BIT_W-1:0]  bitCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic              syncA, syncB, syncC;
  logic              startAcc, halfHit, riseEv, active;

  assign limIn    = (divSel < MIN_LIM) ? MIN_LIM : divSel;
  assign startAcc = start & ~busyR;
  assign active   = busyR & ~finPend;
  assign halfHit  = active & modeR & (halfCnt == limR);
  assign riseEv   = active & (modeR ? (halfHit & ~sclkR) : (syncB & ~syncC));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyR    <= 1'b0;
      doneR    <= 1'b0;
      modeR    <= 1'b0;
      sclkR    <= 1'b1;
      finPend  <= 1'b0;
      holdPend <= 1'b0;
      limR     <= MIN_LIM;
      halfCnt  <= '0;
      bitCnt   <= '0;
      holdCnt  <= '0;
      syncA    <= 1'b1;
      syncB    <= 1'b1;
      syncC    <= 1'b1;
    end else begin
      syncA <= sclkIn;
      syncB <= syncA;
      syncC <= syncB;
      if (startAcc) begin
        busyR    <= 1'b1;
        doneR    <= 1'b0;
        modeR    <= masterMode;
        limR     <= limIn;
        halfCnt  <= '0;
        sclkR    <= 1'b1;
        bitCnt   <= '0;
        holdPend <= 1'b0;
        finPend  <= 1'b0;
      end else if (busyR) begin
        if (holdPend) begin
          if (holdCnt == '0) holdPend <= 1'b0;
          else               holdCnt  <= holdCnt - 1'b1;
        end
        if (finPend) begin
          busyR   <= 1'b0;
          doneR   <= 1'b1;
          finPend <= 1'b0;
        end else begin
          if (modeR) begin
            if (halfHit) begin
              halfCnt <= '0;
              sclkR   <= ~sclkR;
            end else begin
              halfCnt <= halfCnt + 1'b1;
            end
          end
          if (riseEv) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == LAST_BIT) begin
              finPend <= 1'b1;
            end else begin
              holdPend <= 1'b1;
              holdCnt  <= HOLD_INIT;
            end
          end
        end
      end
    end
  end

  always_comb begin
    ctl.loadTx    = startAcc;
    ctl.sampleRx  = riseEv;
    ctl.driveNext = busyR & holdPend & (holdCnt == '0);
    ctl.captureRx = finPend;
  end

  assign busy    = busyR;
  assign done    = doneR;
  assign sclkOut = sclkR;
  assign sclkOe  = modeR;

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyR |-> sclkR);
  // R2
  half_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyR && modeR) |-> (halfCnt <= limR));
  // R5
  busy_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busyR && doneR));
  // R5
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneR) |-> $fell(busyR));
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyR && !finPend) |=> busyR);
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_W    = 12,
  parameter int MIN_HALF = 7,
  parameter int HOLD_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic [DIV_W-1:0]  divSel,
  input  logic [DATA_W-1:0] txData,
  input  logic              start,
  input  logic              rxd,
  input  logic              sclkIn,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rxData,
  output logic              txd,
  output logic              sclkOut,
  output logic              sclkOe
);
  shiftCtl_t ctl;

  ssp_ctrl #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .MIN_HALF(MIN_HALF), .HOLD_CYC(HOLD_CYC)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .masterMode(masterMode),
    .divSel(divSel), .sclkIn(sclkIn), .ctl(ctl), .busy(busy), .done(done),
    .sclkOut(sclkOut), .sclkOe(sclkOe)
  );

  ssp_datapath #(
    .DATA_W(DATA_W), .HOLD_CYC(HOLD_CYC)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .txData(txData), .rxd(rxd),
    .txd(txd), .rxData(rxData)
  );
endmodule

// File: tb/test_sync_serial_port.sv
module test_sync_serial_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        masterMode = 1'b0;
  logic [11:0] divSel = '0;
  logic [7:0]  txData = '0;
  logic        start = 1'b0;
  logic        rxd = 1'b0;
  logic        sclkIn = 1'b1;
  logic        busy, done, txd, sclkOut, sclkOe;
  logic [7:0]  rxData;
  int          checks = 0;
  int          errors = 0;
  int          tick = 0;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) tick <= tick + 1;

  sync_serial_port i_sync_serial_port (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .divSel(divSel),
    .txData(txData), .start(start), .rxd(rxd), .sclkIn(sclkIn),
    .busy(busy), .done(done), .rxData(rxData), .txd(txd),
    .sclkOut(sclkOut), .sclkOe(sclkOe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic resetCheck();
    chk(busy == 0, "R1 busy", busy, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(rxData == 0, "R1 rxData", rxData, 0);
    chk(txd == 1, "R1 txd", txd, 1);
    chk(sclkOut == 1, "R1 sclkOut", sclkOut, 1);
    chk(sclkOe == 0, "R1 sclkOe", sclkOe, 0);
  endtask

  // master transfer; disturb pulses start and changes mode/divider mid-transfer (R8, R9)
  task automatic masterXfer(input logic [7:0] tx, input logic [7:0] rx,
                            input logic [11:0] div, input int expHalf, input bit disturb);
    int tAcc;
    int lastFall;
    @(negedge clk);
    masterMode = 1'b1; divSel = div; txData = tx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tAcc = tick;
    chk(busy == 1, "R5 busy after start", busy, 1);
    chk(done == 0, "R5 done cleared", done, 0);
    chk(txd == tx[0], "R3 first bit", txd, tx[0]);
    chk(sclkOe == 1, "R2 sclkOe", sclkOe, 1);
    if (disturb) begin
      divSel = div + 12'd5; masterMode = 1'b0; txData = ~tx; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1, "R8 busy kept", busy, 1);
    end
    lastFall = tAcc;
    for (int k = 0; k < 8; k++) begin
      @(negedge sclkOut);
      @(negedge clk);
      rxd = rx[k];
      if (k == 0) chk(tick - tAcc == expHalf, "R2 R6 R9 first fall", tick - tAcc, expHalf);
      else if (k < 3) chk(tick - lastFall == 2 * expHalf, "R2 R6 R9 period",
                          tick - lastFall, 2 * expHalf);
      lastFall = tick;
      @(posedge sclkOut);
      @(negedge clk);
      chk(txd == tx[k], "R3 bit held at rise", txd, tx[k]);
      if (k < 7) begin
        @(negedge clk);
        chk(txd == tx[k], "R3 bit held one cycle", txd, tx[k]);
        @(negedge clk);
        chk(txd == tx[k+1], "R3 next bit", txd, tx[k+1]);
      end else begin
        chk(busy == 1, "R5 busy at last rise", busy, 1);
        @(negedge clk);
        chk(busy == 0, "R5 busy falls", busy, 0);
        chk(done == 1, "R5 done set", done, 1);
        chk(rxData == rx, "R4 rxData", rxData, rx);
      end
    end
    chk(sclkOe == 1, "R9 sclkOe kept", sclkOe, 1);
    repeat (5) @(negedge clk);
    chk(txd == tx[7], "R10 txd holds last bit", txd, tx[7]);
    chk(sclkOut == 1, "R2 idle high", sclkOut, 1);
  endtask

  task automatic slaveXfer(input logic [7:0] tx, input logic [7:0] rx, input int halfP);
    @(negedge clk);
    masterMode = 1'b0; sclkIn = 1'b1; txData = tx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1, "R7 busy", busy, 1);
    chk(done == 0, "R5 done cleared", done, 0);
    chk(sclkOe == 0, "R7 sclkOe", sclkOe, 0);
    for (int k = 0; k < 8; k++) begin
      repeat (halfP) @(negedge clk);
      chk(txd == tx[k], "R7 R3 txd before fall", txd, tx[k]);
      sclkIn = 1'b0; rxd = rx[k];
      repeat (halfP) @(negedge clk);
      chk(sclkOut == 1, "R7 sclkOut high", sclkOut, 1);
      sclkIn = 1'b1;
    end
    repeat (2) @(negedge clk);
    chk(busy == 1, "R7 sync latency busy", busy, 1);
    repeat (2) @(negedge clk);
    chk(done == 1, "R7 done latency", done, 1);
    chk(busy == 0, "R7 busy falls", busy, 0);
    chk(rxData == rx, "R7 R4 rxData", rxData, rx);
    repeat (4) @(negedge clk);
    chk(txd == tx[7], "R10 slave txd holds", txd, tx[7]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", tick, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    resetCheck();
    rstN = 1'b1;
    @(negedge clk);
    resetCheck();
    masterXfer(8'hA5, 8'h3C, 12'd9, 10, 1'b0);
    masterXfer(8'h81, 8'hE7, 12'd3, 8, 1'b0);
    masterXfer(8'h5A, 8'h01, 12'd7, 8, 1'b0);
    masterXfer(8'hC6, 8'h92, 12'd12, 13, 1'b1);
    slaveXfer(8'h6D, 8'hB4, 8);
    slaveXfer(8'h13, 8'h7E, 13);
    masterXfer(8'hFE, 8'h80, 12'd20, 21, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule